// File: doc/BRIEF.md
# Overload and Thermal Restart Sequencer

This block decides, cycle by cycle, whether the regulated output of a supply stage may be driven, given two fault indications from analog sensing: an overcurrent flag and an overtemperature flag. Both arrive asynchronously and pass through a two-flop synchronizer. A 1 ms enable pulse from an external prescaler is the time base for every window the sequencer counts.

With dynamic limiting chosen, an overcurrent does not drop the output at once. The output is kept on for an on window, then forced off for a much longer off window, and then given another on window. This repeats until an on window passes with no overcurrent seen. With static limiting chosen, the sequencer only raises the overcurrent flag request and leaves the output alone. Overtemperature forces the output off and takes precedence over the overcurrent cycle. For each fault kind, a policy input chooses between automatic restart and latch-off. Latch-off asks the host to clear its voltage selection and keeps the output off until that selection has been cleared and written again.

Top module: `fault_restart_seq`

## Requirements
- R1: After reset, outEnable, olFlagSet, otFlagSet and clrVoltSel are all 0.
- R2: When voltSel is all zero (standby), outEnable is 0 from the next clock edge on, in every state.
- R3: With staticLimit=0, a synchronized overcurrent starts an on window of ON_TICKS msTick pulses with the output enabled. If overcurrent was seen during that window, the output is disabled when the window ends, and olFlagSet is 1 for exactly that one cycle.
- R4: The output then stays disabled for exactly OFF_TICKS msTick pulses, after which it is enabled again for a new on window.
- R5: If overcurrent is seen at any time during a retry on window, that window also lasts exactly ON_TICKS pulses and is followed by another off window.
- R6: An on window with no overcurrent seen returns the block to normal operation. The output stays enabled and olFlagSet stays 0.
- R7: With staticLimit=1, the output stays enabled while overcurrent persists, and olFlagSet is 1 in each cycle that the synchronized overcurrent is present.
- R8: With olLatchOff=1, an on window that ends with overcurrent seen enters a hold state. In hold, outEnable is 0 and clrVoltSel is 1 until voltSel reads all zero. After that the output follows voltSel again.
- R9: While synchronized overtemperature is present, the output is disabled and otFlagSet is 1.
- R10: With thLatchOff=0, the output re-enables by itself once overtemperature clears.
- R11: With thLatchOff=1, clearing overtemperature enters the same hold state as R8.
- R12: Overtemperature takes precedence over the overcurrent cycle. While it is present, no on window, off window or olFlagSet occurs.
- R13: A fault input that becomes valid before a clock edge shows its effect on the outputs just after the third rising edge, and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| msTick | input | 1 | One-cycle pulse every millisecond |
| overloadIn | input | 1 | Asynchronous overcurrent indication |
| overTempIn | input | 1 | Asynchronous overtemperature indication |
| staticLimit | input | 1 | 1 = static clamp (flag only), 0 = dynamic on/off retry |
| olLatchOff | input | 1 | Overcurrent restart policy: 1 = latch-off, 0 = auto restart |
| thLatchOff | input | 1 | Thermal restart policy: 1 = latch-off, 0 = auto restart |
| voltSel | input | VSEL_W | Current host voltage selection; all zero means standby |
| outEnable | output | 1 | Output stage enable |
| olFlagSet | output | 1 | Request to set the overcurrent diagnostic flag |
| otFlagSet | output | 1 | Request to set the overtemperature diagnostic flag |
| clrVoltSel | output | 1 | Request to clear the host voltage selection |

## Verification
The retry cycle is driven with a persistent short, which tells apart the window lengths: msTick pulses are counted while the output is off and while it is on. It is also driven with a short that goes away during an off window, which separates a return to normal from another retry. Overtemperature is raised inside a running on window, which shows both the three-edge latency and that thermal handling suppresses the overcurrent cycle. Each policy bit is then exercised in both settings to tell auto restart apart from hold. A long run of randomly mixed fault levels, policies, standby selections and tick phases is compared every cycle against a reference model in the bench.

// File: rtl/fault_seq_pkg.sv
package fault_seq_pkg;

  typedef enum logic [2:0] {
    ST_RUN    = 3'd0,
    ST_ONWIN  = 3'd1,
    ST_OFFWIN = 3'd2,
    ST_THERM  = 3'd3,
    ST_HOLD   = 3'd4
  } seqState_t;

  // strobes from the control FSM to the datapath
  typedef struct packed {
    logic cntClr;      // restart the tick counter
    logic sawLoad;     // load the overcurrent-seen register
    logic sawInit;     // value loaded into it
    logic enNext;      // next outEnable
    logic olFlagNext;  // next olFlagSet
    logic otFlagNext;  // next otFlagSet
    logic clrNext;     // next clrVoltSel
  } seqStrobe_t;

endpackage

// File: rtl/fault_sync.sv
module fault_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic asyncIn,
  output logic syncOut
);

  logic [STAGES-1:0] chain;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) chain[0] <= 1'b0;
          else       chain[0] <= asyncIn;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) chain[i] <= 1'b0;
          else       chain[i] <= chain[i-1];
        end
      end
    end
  endgenerate

  assign syncOut = chain[STAGES-1];

endmodule

// File: rtl/fault_seq_dp.sv
module fault_seq_dp
  import fault_seq_pkg::*;
#(
  parameter int ON_TICKS    = 90,
  parameter int OFF_TICKS   = 900,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       msTick,
  input  logic       overloadIn,
  input  logic       overTempIn,
  input  seqStrobe_t strobe,
  output logic       olSync,
  output logic       otSync,
  output logic       onDone,
  output logic       offDone,
  output logic       sawOl,
  output logic       outEnable,
  output logic       olFlagSet,
  output logic       otFlagSet,
  output logic       clrVoltSel
);

  localparam int MAX_TICKS = (ON_TICKS > OFF_TICKS) ? ON_TICKS : OFF_TICKS;
  localparam int CNT_W     = $clog2(MAX_TICKS + 1);
  localparam logic [CNT_W-1:0] CNT_MAX  = CNT_W'(MAX_TICKS - 1);
  localparam logic [CNT_W-1:0] ON_LAST  = CNT_W'(ON_TICKS - 1);
  localparam logic [CNT_W-1:0] OFF_LAST = CNT_W'(OFF_TICKS - 1);

  logic [1:0] faultRaw;
  logic [1:0] faultSync;
  logic [CNT_W-1:0] tickCnt;

  assign faultRaw = {overTempIn, overloadIn};

  generate
    for (genvar k = 0; k < 2; k++) begin : g_sync
      fault_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rstN   (rstN),
        .asyncIn(faultRaw[k]),
        .syncOut(faultSync[k])
      );
    end
  endgenerate

  assign olSync = faultSync[0];
  assign otSync = faultSync[1];

  // tick counter, saturating
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                          tickCnt <= '0;
    else if (strobe.cntClr)             tickCnt <= '0;
    else if (msTick && tickCnt != CNT_MAX) tickCnt <= tickCnt + 1'b1;
  end

  assign onDone  = msTick && (tickCnt == ON_LAST);
  assign offDone = msTick && (tickCnt == OFF_LAST);

  // overcurrent seen during the current on window
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              sawOl <= 1'b0;
    else if (strobe.sawLoad) sawOl <= strobe.sawInit;
    else if (olSync)         sawOl <= 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outEnable  <= 1'b0;
      olFlagSet  <= 1'b0;
      otFlagSet  <= 1'b0;
      clrVoltSel <= 1'b0;
    end else begin
      outEnable  <= strobe.enNext;
      olFlagSet  <= strobe.olFlagNext;
      otFlagSet  <= strobe.otFlagNext;
      clrVoltSel <= strobe.clrNext;
    end
  end

  // R4
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rstN)
    tickCnt <= CNT_MAX);

  // R9
  therm_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    otSync |=> (otFlagSet && !outEnable));

endmodule

// File: rtl/fault_seq_ctrl.sv
module fault_seq_ctrl
  import fault_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       olSync,
  input  logic       otSync,
  input  logic       onDone,
  input  logic       offDone,
  input  logic       sawOl,
  input  logic       staticLimit,
  input  logic       olLatchOff,
  input  logic       thLatchOff,
  input  logic       voltActive,
  output seqStrobe_t strobe
);

  seqState_t state, stateNext;
  logic      winFault;
  logic      olFlagNow;

  assign winFault = sawOl || olSync;

  always_comb begin
    stateNext   = state;
    strobe      = '0;
    olFlagNow   = 1'b0;
    unique case (state)
      ST_RUN: begin
        if (otSync) begin
          stateNext = ST_THERM;
        end else if (olSync && !staticLimit) begin
          stateNext      = ST_ONWIN;
          strobe.cntClr  = 1'b1;
          strobe.sawLoad = 1'b1;
          strobe.sawInit = 1'b1;
        end else if (olSync) begin
          olFlagNow = 1'b1;
        end
      end
      ST_ONWIN: begin
        if (otSync) begin
          stateNext = ST_THERM;
        end else if (onDone) begin
          if (winFault) begin
            olFlagNow     = 1'b1;
            stateNext     = olLatchOff ? ST_HOLD : ST_OFFWIN;
            strobe.cntClr = 1'b1;
          end else begin
            stateNext = ST_RUN;
          end
        end
      end
      ST_OFFWIN: begin
        if (otSync) begin
          stateNext = ST_THERM;
        end else if (offDone) begin
          stateNext      = ST_ONWIN;
          strobe.cntClr  = 1'b1;
          strobe.sawLoad = 1'b1;
          strobe.sawInit = 1'b0;
        end
      end
      ST_THERM: begin
        if (!otSync) stateNext = thLatchOff ? ST_HOLD : ST_RUN;
      end
      ST_HOLD: begin
        if (otSync)           stateNext = ST_THERM;
        else if (!voltActive) stateNext = ST_RUN;
      end
      default: stateNext = ST_RUN;
    endcase
    strobe.olFlagNext = olFlagNow;
    strobe.otFlagNext = (stateNext == ST_THERM);
    strobe.clrNext    = (stateNext == ST_HOLD);
    strobe.enNext     = voltActive &&
                        ((stateNext == ST_RUN) || (stateNext == ST_ONWIN));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_RUN;
    else       state <= stateNext;
  end

  // R4
  off_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_OFFWIN && !offDone && !otSync) |=> (state == ST_OFFWIN));

  // R7
  static_stay_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_RUN && staticLimit && olSync && !otSync) |=> (state == ST_RUN));

  // R12
  therm_prio_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_THERM && otSync) |=> (state == ST_THERM));

endmodule

// File: rtl/fault_restart_seq.sv
module fault_restart_seq
  import fault_seq_pkg::*;
#(
  parameter int VSEL_W      = 4,
  parameter int ON_TICKS    = 90,
  parameter int OFF_TICKS   = 900,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              msTick,
  input  logic              overloadIn,
  input  logic              overTempIn,
  input  logic              staticLimit,
  input  logic              olLatchOff,
  input  logic              thLatchOff,
  input  logic [VSEL_W-1:0] voltSel,
  output logic              outEnable,
  output logic              olFlagSet,
  output logic              otFlagSet,
  output logic              clrVoltSel
);

  seqStrobe_t strobe;
  logic olSync, otSync, onDone, offDone, sawOl;
  logic voltActive;

  assign voltActive = |voltSel;

  fault_seq_dp #(
    .ON_TICKS   (ON_TICKS),
    .OFF_TICKS  (OFF_TICKS),
    .SYNC_STAGES(SYNC_STAGES)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .msTick    (msTick),
    .overloadIn(overloadIn),
    .overTempIn(overTempIn),
    .strobe    (strobe),
    .olSync    (olSync),
    .otSync    (otSync),
    .onDone    (onDone),
    .offDone   (offDone),
    .sawOl     (sawOl),
    .outEnable (outEnable),
    .olFlagSet (olFlagSet),
    .otFlagSet (otFlagSet),
    .clrVoltSel(clrVoltSel)
  );

  fault_seq_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .olSync     (olSync),
    .otSync     (otSync),
    .onDone     (onDone),
    .offDone    (offDone),
    .sawOl      (sawOl),
    .staticLimit(staticLimit),
    .olLatchOff (olLatchOff),
    .thLatchOff (thLatchOff),
    .voltActive (voltActive),
    .strobe     (strobe)
  );

  // R2
  standby_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    (voltSel == '0) |=> !outEnable);

  // R8
  hold_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    clrVoltSel |-> !outEnable);

endmodule

// File: tb/fault_restart_seq_tb.sv
module fault_restart_seq_tb;

  localparam int VW       = 4;
  localparam int ON_T     = 3;
  localparam int OFF_T    = 20;
  localparam int TICK_DIV = 4;

  localparam int S_RUN = 0, S_ON = 1, S_OFF = 2, S_TH = 3, S_HOLD = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic msTick = 1'b0;
  logic overloadIn = 1'b0;
  logic overTempIn = 1'b0;
  logic staticLimit = 1'b0;
  logic olLatchOff = 1'b0;
  logic thLatchOff = 1'b0;
  logic [VW-1:0] voltSel = '0;
  logic outEnable, olFlagSet, otFlagSet, clrVoltSel;

  int errors = 0;
  int checks = 0;
  int tickPh = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  fault_restart_seq #(.VSEL_W(VW), .ON_TICKS(ON_T), .OFF_TICKS(OFF_T)) u_dut (
    .clk(clk), .rstN(rstN), .msTick(msTick), .overloadIn(overloadIn),
    .overTempIn(overTempIn), .staticLimit(staticLimit), .olLatchOff(olLatchOff),
    .thLatchOff(thLatchOff), .voltSel(voltSel), .outEnable(outEnable),
    .olFlagSet(olFlagSet), .otFlagSet(otFlagSet), .clrVoltSel(clrVoltSel)
  );

  // reference model of the requirements
  bit [1:0] mOl, mOt;
  int mSt, mCnt;
  bit mSaw, mEn, mOlF, mOtF, mClr;

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mOl = 0; mOt = 0; mSt = S_RUN; mCnt = 0; mSaw = 0;
      mEn = 0; mOlF = 0; mOtF = 0; mClr = 0;
    end else begin
      bit olS, otS, onD, offD, clr, ld, ini, flag;
      int nSt;
      olS = mOl[1]; otS = mOt[1];
      onD = msTick && (mCnt == ON_T - 1);
      offD = msTick && (mCnt == OFF_T - 1);
      nSt = mSt; clr = 0; ld = 0; ini = 0; flag = 0;
      case (mSt)
        S_RUN:  if (otS) nSt = S_TH;
                else if (olS && !staticLimit) begin nSt = S_ON; clr = 1; ld = 1; ini = 1; end
                else if (olS) flag = 1;
        S_ON:   if (otS) nSt = S_TH;
                else if (onD) begin
                  if (mSaw || olS) begin flag = 1; clr = 1; nSt = olLatchOff ? S_HOLD : S_OFF; end
                  else nSt = S_RUN;
                end
        S_OFF:  if (otS) nSt = S_TH;
                else if (offD) begin nSt = S_ON; clr = 1; ld = 1; ini = 0; end
        S_TH:   if (!otS) nSt = thLatchOff ? S_HOLD : S_RUN;
        default: if (otS) nSt = S_TH; else if (voltSel == 0) nSt = S_RUN;
      endcase
      if (clr) mCnt = 0;
      else if (msTick && mCnt != OFF_T - 1) mCnt = mCnt + 1;
      if (ld) mSaw = ini; else if (olS) mSaw = 1;
      mOl = {mOl[0], overloadIn};
      mOt = {mOt[0], overTempIn};
      mSt = nSt;
      mOlF = flag;
      mOtF = (nSt == S_TH);
      mClr = (nSt == S_HOLD);
      mEn = (voltSel != 0) && (nSt == S_RUN || nSt == S_ON);
    end
  end

  function automatic string tagOf();
    if (mOtF) return "R9";
    if (mClr) return "R8";
    if (mSt == S_OFF) return "R4";
    if (mSt == S_ON) return "R3";
    if (!mEn) return "R2";
    return "R6";
  endfunction

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // one clock: sample at negedge, compare with model, drive next tick
  task automatic stepCycle();
    @(negedge clk);
    if (rstN) begin
      bit [3:0] act, exp;
      act = {outEnable, olFlagSet, otFlagSet, clrVoltSel};
      exp = {mEn, mOlF, mOtF, mClr};
      chk(act == exp, tagOf(), "outputs {en,olf,otf,clr}", act, exp);
    end
    msTick = (tickPh == TICK_DIV - 1);
    tickPh = (tickPh + 1) % TICK_DIV;
  endtask

  task automatic steps(int n);
    for (int i = 0; i < n; i++) stepCycle();
  endtask

  task automatic waitEn(bit lvl, string req);
    int t = 0;
    while (outEnable !== lvl && t < 2000) begin stepCycle(); t++; end
    chk(outEnable === lvl, req, "outEnable reached level", outEnable, lvl);
  endtask

  task automatic doReset();
    rstN = 1'b0; overloadIn = 0; overTempIn = 0;
    steps(3);
    rstN = 1'b1;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL R1 watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int cnt;
    bit bad;
    void'($urandom(32'h5eed));
    doReset();
    steps(1);
    // R1 reset state
    chk({outEnable, olFlagSet, otFlagSet, clrVoltSel} == 4'b0, "R1", "reset outputs",
        {outEnable, olFlagSet, otFlagSet, clrVoltSel}, 0);

    // R2 standby then selection
    steps(5);
    chk(outEnable == 0, "R2", "standby enable", outEnable, 0);
    voltSel = 4'd5;
    steps(2);
    chk(outEnable == 1, "R2", "enable after selection", outEnable, 1);

    // R7 static clamp
    staticLimit = 1; overloadIn = 1;
    steps(3);
    chk(olFlagSet == 1, "R7", "static flag", olFlagSet, 1);
    bad = 0;
    for (int i = 0; i < 50; i++) begin stepCycle(); if (!outEnable || !olFlagSet) bad = 1; end
    chk(!bad, "R7", "static enable and flag held", bad, 0);
    overloadIn = 0;
    steps(4);
    chk(olFlagSet == 0, "R7", "static flag released", olFlagSet, 0);

    // R3 R4 R5 dynamic retry with persistent short
    staticLimit = 0; overloadIn = 1;
    waitEn(0, "R3");
    chk(olFlagSet == 1, "R3", "flag at shutdown", olFlagSet, 1);
    cnt = 0;
    while (!outEnable && cnt < 1000) begin cnt += msTick; stepCycle(); end
    chk(cnt == OFF_T, "R4", "ticks while off", cnt, OFF_T);
    cnt = 0;
    while (outEnable && cnt < 1000) begin cnt += msTick; stepCycle(); end
    chk(cnt == ON_T, "R5", "ticks in retry window", cnt, ON_T);
    chk(olFlagSet == 1, "R5", "flag at second shutdown", olFlagSet, 1);

    // R6 short removed during off window
    overloadIn = 0;
    waitEn(1, "R6");
    bad = 0;
    for (int i = 0; i < 150; i++) begin stepCycle(); if (!outEnable || olFlagSet) bad = 1; end
    chk(!bad, "R6", "normal after clean window", bad, 0);

    // R8 overcurrent latch-off
    olLatchOff = 1; overloadIn = 1;
    waitEn(0, "R8");
    steps(1);
    chk(clrVoltSel == 1, "R8", "clear request", clrVoltSel, 1);
    overloadIn = 0;
    bad = 0;
    for (int i = 0; i < 60; i++) begin stepCycle(); if (outEnable || !clrVoltSel) bad = 1; end
    chk(!bad, "R8", "held off until cleared", bad, 0);
    voltSel = 0;
    steps(2);
    chk(clrVoltSel == 0, "R8", "clear released", clrVoltSel, 0);
    voltSel = 4'd6;
    steps(2);
    chk(outEnable == 1, "R8", "rewrite enables", outEnable, 1);
    olLatchOff = 0;

    // R13 R9 R12 thermal inside an on window
    overloadIn = 1;
    steps(5);
    overTempIn = 1;
    stepCycle();
    chk(outEnable == 1, "R13", "after edge 1", outEnable, 1);
    stepCycle();
    chk(outEnable == 1, "R13", "after edge 2", outEnable, 1);
    stepCycle();
    chk(outEnable == 0 && otFlagSet == 1, "R13", "after edge 3 off+flag",
        {outEnable, otFlagSet}, 2'b01);
    bad = 0;
    for (int i = 0; i < 200; i++) begin
      stepCycle();
      if (outEnable || olFlagSet || !otFlagSet) bad = 1;
    end
    chk(!bad, "R12", "thermal suppresses overcurrent cycle", bad, 0);
    chk(otFlagSet == 1, "R9", "thermal flag", otFlagSet, 1);

    // R10 auto restart
    overloadIn = 0; overTempIn = 0;
    steps(3);
    chk(outEnable == 1 && otFlagSet == 0, "R10", "auto re-enable",
        {outEnable, otFlagSet}, 2'b10);

    // R11 thermal latch-off
    steps(10);
    thLatchOff = 1; overTempIn = 1;
    steps(10);
    overTempIn = 0;
    steps(3);
    chk(outEnable == 0 && clrVoltSel == 1, "R11", "hold after thermal",
        {outEnable, clrVoltSel}, 2'b01);
    steps(20);
    chk(outEnable == 0, "R11", "still off", outEnable, 0);
    voltSel = 0; steps(2);
    voltSel = 4'd2; steps(2);
    chk(outEnable == 1, "R11", "rewrite enables", outEnable, 1);
    thLatchOff = 0;

    // random mix compared against the model every cycle
    for (int seg = 0; seg < 400; seg++) begin
      int len = 1 + ($urandom % 200);
      overloadIn  = ($urandom % 3) == 0;
      overTempIn  = ($urandom % 8) == 0;
      staticLimit = ($urandom % 4) == 0;
      olLatchOff  = ($urandom % 3) == 0;
      thLatchOff  = ($urandom % 3) == 0;
      voltSel     = (($urandom % 6) == 0) ? '0 : VW'($urandom);
      if (clrVoltSel && ($urandom % 2)) voltSel = '0;
      steps(len);
    end
    if (($urandom % 2) == 0) doReset(); else steps(2);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule